// File: doc/BRIEF.md
# Write-Once Snooping Cache Controller

This block is the coherence controller that sits between one processor and a shared snooping bus. It keeps a small direct-mapped cache, one data word per line, and runs a four-state write-invalidate scheme. The first write to a shared line goes straight through to memory and invalidates all other copies in one bus transaction. Later writes to the same line stay in the cache until the line is evicted or another controller asks for it.

The processor side presents a request and is held with a stall until the access can finish. The bus side issues fetches, fetches-for-ownership, the combined write-through/invalidate and write-backs, each with a request/grant/done handshake. The snoop side watches other controllers' bus commands. It drops or downgrades matching lines, and it raises an intervention strobe with the line data whenever it holds the only up-to-date copy.

Top module: `wo_snoop_ctrl`

## Requirements
- R1: After synchronous active-low reset every line is Invalid, so the first access to any address goes to the bus. `cpu_stall`, `bus_req` and `snp_itv` are low while no request is present.
- R2: A read that hits a line in any non-Invalid state finishes in the cycle it is presented (`cpu_stall` low), returns the line word on `cpu_rdata` and issues no bus transaction.
- R3: A read miss issues one fetch (`bus_cmd` 3'd1) for the request address and fills the line as Valid with `bus_rdata`, whoever supplied that word. The read then completes with that word.
- R4: A write hit on a Valid line issues one combined write-through/invalidate (`bus_cmd` 3'd2) that carries the address and the new word, and leaves the line Reserved. The processor is stalled until the bus has granted and completed it. `bus_req`, `bus_cmd`, `bus_addr` and `bus_wdata` hold steady until the grant.
- R5: A write hit on a Reserved or Dirty line finishes with no stall and no bus traffic, and leaves the line Dirty with the new word.
- R6: A write miss issues one fetch-for-ownership (`bus_cmd` 3'd3) and stores the written word in the line as Dirty. Memory is not written.
- R7: On a miss, a Dirty victim is first written back (`bus_cmd` 3'd4) with its own address (stored tag above the index) and word, and the fetch follows. Valid and Reserved victims are replaced with no write-back.
- R8: A snooped fetch (`snp_cmd` 3'd1) that matches a Reserved line moves it to Valid without intervention.
- R9: A snooped fetch that matches a Dirty line raises `snp_itv` in that cycle with the line word on `snp_data` and moves the line to Valid.
- R10: A snooped write-through/invalidate (3'd2) or fetch-for-ownership (3'd3) that matches a non-Invalid line makes it Invalid. A Dirty line raises `snp_itv` with its word first. A snoop whose tag differs from the line's tag has no effect.
- R11: While `snp_valid` addresses the same index as the processor request, the processor access does not complete (`cpu_stall` high). The snoop update of that line always takes effect.
- Address layout: the low `IDX_W` bits of an address select the line, the remaining upper bits form the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until accepted |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write word |
| cpu_rdata | output | DATA_W | Read word, valid when the read completes |
| cpu_stall | output | 1 | Request cannot complete this cycle |
| bus_req | output | 1 | Bus transaction requested |
| bus_gnt | input | 1 | Bus grant |
| bus_done | input | 1 | Granted transaction finished |
| bus_cmd | output | 3 | 1 fetch, 2 write-through/invalidate, 3 fetch-for-ownership, 4 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Word for write-through or write-back |
| bus_rdata | input | DATA_W | Word returned with `bus_done` |
| snp_valid | input | 1 | Another controller's command is on the bus |
| snp_cmd | input | 3 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_itv | output | 1 | This cache supplies the word |
| snp_data | output | DATA_W | Supplied word |

## Verification
The assertions check on every cycle that a pending bus request keeps its command, address and word until granted. They also check that the idle controller never requests the bus, that a write-back is always followed by a fetch, that every intervention accompanies a snoop, and that a snoop state update lands even when the processor writes the same line in that cycle. The state sequences themselves can only be shown by the bench scenarios: Valid to Reserved to Dirty, downgrade on a snooped read, victim write-back versus silent drop, and a fill from another cache's data. The bench infers each line's state from the bus traffic and the intervention strobes that later accesses produce.

// File: rtl/wo_pkg.sv
// Package: shared types for the write-once snooping controller.
// Assumes one word per line; encodings are visible on the bus pins.
package wo_pkg;
    typedef enum logic [1:0] {
        LN_INV   = 2'd0,
        LN_VAL   = 2'd1,
        LN_RES   = 2'd2,
        LN_DIRTY = 2'd3
    } line_st_t;

    typedef enum logic [2:0] {
        BC_NONE  = 3'd0,
        BC_READ  = 3'd1,
        BC_WTI   = 3'd2,
        BC_RFO   = 3'd3,
        BC_WB    = 3'd4
    } bus_cmd_t;

    typedef enum logic [2:0] {
        F_IDLE, F_WB, F_FETCH, F_WTI, F_DONE
    } fsm_t;
endpackage

// File: rtl/wo_line_store.sv
// Line store: direct-mapped state/tag/data arrays, two read ports
// (processor index, snoop index), a full processor write port and a
// state-only snoop write port. Assumes the snoop write wins on a clash.
module wo_line_store
    import wo_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  a_idx,
    output line_st_t          a_st,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    input  logic [IDX_W-1:0]  b_idx,
    output line_st_t          b_st,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data,
    input  logic              pw_en,
    input  logic [IDX_W-1:0]  pw_idx,
    input  logic [TAG_W-1:0]  pw_tag,
    input  logic [DATA_W-1:0] pw_data,
    input  line_st_t          pw_st,
    input  logic              sw_en,
    input  logic [IDX_W-1:0]  sw_idx,
    input  line_st_t          sw_st
);
    localparam int DEPTH = 1 << IDX_W;

    line_st_t          st_q   [DEPTH];
    logic [TAG_W-1:0]  tag_q  [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];

    // Read ports are plain array lookups.
    assign a_st   = st_q[a_idx];
    assign a_tag  = tag_q[a_idx];
    assign a_data = data_q[a_idx];
    assign b_st   = st_q[b_idx];
    assign b_tag  = tag_q[b_idx];
    assign b_data = data_q[b_idx];

    // Line states: clear on reset, snoop update issued last so it wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) st_q[i] <= LN_INV;
        end else begin
            if (pw_en) st_q[pw_idx] <= pw_st;
            if (sw_en) st_q[sw_idx] <= sw_st;
        end
    end

    // Tag and data written only by the processor side.
    always_ff @(posedge clk) begin
        if (pw_en) begin
            tag_q[pw_idx]  <= pw_tag;
            data_q[pw_idx] <= pw_data;
        end
    end

    // R11: a snoop state update is never lost to a same-cycle processor write.
    p_snoop_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sw_en |=> st_q[$past(sw_idx)] == $past(sw_st));
endmodule

// File: rtl/wo_snoop_unit.sv
// Snoop unit: decides, combinationally, how another controller's bus
// command affects the line at its index and whether to intervene.
// Assumes the snooped command is present for exactly one cycle.
module wo_snoop_unit
    import wo_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              snp_valid,
    input  logic [2:0]        snp_cmd,
    input  logic [TAG_W-1:0]  snp_tag,
    input  line_st_t          l_st,
    input  logic [TAG_W-1:0]  l_tag,
    input  logic [DATA_W-1:0] l_data,
    output logic              itv,
    output logic [DATA_W-1:0] itv_data,
    output logic              upd_en,
    output line_st_t          upd_st
);
    logic match;

    // Response to a snooped command: downgrade, invalidate, intervene.
    always_comb begin
        match  = snp_valid && (l_st != LN_INV) && (l_tag == snp_tag);
        itv    = 1'b0;
        upd_en = 1'b0;
        upd_st = l_st;
        case (bus_cmd_t'(snp_cmd))
            BC_READ: begin
                if (match && (l_st == LN_RES || l_st == LN_DIRTY)) begin
                    upd_en = 1'b1;
                    upd_st = LN_VAL;
                    itv    = (l_st == LN_DIRTY);
                end
            end
            BC_WTI, BC_RFO: begin
                if (match) begin
                    upd_en = 1'b1;
                    upd_st = LN_INV;
                    itv    = (l_st == LN_DIRTY);
                end
            end
            default: ;
        endcase
        itv_data = itv ? l_data : '0;
    end
endmodule

// File: rtl/wo_ctrl_fsm.sv
// Control FSM: serves hits locally, sequences write-back, fetch and
// write-through/invalidate transactions, and stalls the processor.
// Assumes the processor holds its request stable while stalled.
module wo_ctrl_fsm
    import wo_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [DATA_W-1:0]       cpu_wdata,
    output logic                    cpu_stall,
    input  logic                    snp_block,
    input  line_st_t                l_st,
    input  logic [ADDR_W-IDX_W-1:0] l_tag,
    input  logic [DATA_W-1:0]       l_data,
    input  logic                    bus_gnt,
    input  logic                    bus_done,
    input  logic [DATA_W-1:0]       bus_rdata,
    output logic                    bus_req,
    output bus_cmd_t                bus_cmd,
    output logic [ADDR_W-1:0]       bus_addr,
    output logic [DATA_W-1:0]       bus_wdata,
    output logic                    pw_en,
    output logic [ADDR_W-IDX_W-1:0] pw_tag,
    output logic [DATA_W-1:0]       pw_data,
    output line_st_t                pw_st
);
    localparam int TAG_W = ADDR_W - IDX_W;

    fsm_t             state_q, state_d;
    logic             gnt_seen_q;
    logic [TAG_W-1:0] cpu_tag;
    logic             hit, serve, in_bus, done_bus;

    assign cpu_tag  = cpu_addr[ADDR_W-1:IDX_W];
    assign hit      = (l_st != LN_INV) && (l_tag == cpu_tag);
    assign serve    = hit && !snp_block &&
                      (!cpu_we || l_st == LN_RES || l_st == LN_DIRTY);
    assign in_bus   = (state_q == F_WB) || (state_q == F_FETCH) || (state_q == F_WTI);
    assign done_bus = gnt_seen_q && bus_done;
    assign bus_req  = in_bus && !gnt_seen_q;

    // Next state, stall, bus command and line write for each state.
    always_comb begin
        state_d   = state_q;
        cpu_stall = 1'b1;
        bus_cmd   = BC_NONE;
        bus_addr  = '0;
        bus_wdata = '0;
        pw_en     = 1'b0;
        pw_tag    = cpu_tag;
        pw_data   = cpu_wdata;
        pw_st     = LN_DIRTY;
        case (state_q)
            F_IDLE: begin
                cpu_stall = cpu_req && !serve;
                if (cpu_req && serve && cpu_we) begin
                    pw_en = 1'b1;
                end else if (cpu_req && hit && cpu_we && l_st == LN_VAL) begin
                    state_d = F_WTI;
                end else if (cpu_req && !hit) begin
                    state_d = (l_st == LN_DIRTY) ? F_WB : F_FETCH;
                end
            end
            F_WB: begin
                bus_cmd   = BC_WB;
                bus_addr  = {l_tag, cpu_addr[IDX_W-1:0]};
                bus_wdata = l_data;
                if (done_bus) begin
                    pw_en   = 1'b1;
                    pw_tag  = l_tag;
                    pw_data = l_data;
                    pw_st   = LN_INV;
                    state_d = F_FETCH;
                end
            end
            F_FETCH: begin
                bus_cmd  = cpu_we ? BC_RFO : BC_READ;
                bus_addr = cpu_addr;
                if (done_bus) begin
                    pw_en   = 1'b1;
                    pw_data = cpu_we ? cpu_wdata : bus_rdata;
                    pw_st   = cpu_we ? LN_DIRTY : LN_VAL;
                    state_d = F_DONE;
                end
            end
            F_WTI: begin
                bus_cmd   = BC_WTI;
                bus_addr  = cpu_addr;
                bus_wdata = cpu_wdata;
                if (done_bus) begin
                    pw_en   = 1'b1;
                    pw_st   = LN_RES;
                    state_d = F_DONE;
                end
            end
            F_DONE: begin
                cpu_stall = 1'b0;
                state_d   = F_IDLE;
            end
            default: state_d = F_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= F_IDLE;
        else        state_q <= state_d;
    end

    // Grant tracker: set at grant, cleared when the transaction is done.
    always_ff @(posedge clk) begin
        if (!rst_n)                 gnt_seen_q <= 1'b0;
        else if (done_bus)          gnt_seen_q <= 1'b0;
        else if (bus_req && bus_gnt) gnt_seen_q <= 1'b1;
    end

    // R4: an ungranted request keeps its command, address and word.
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req && $stable(bus_cmd) &&
                                  $stable(bus_addr) && $stable(bus_wdata));
    // R2: the idle controller never asks for the bus.
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == F_IDLE) |-> !bus_req);
    // R7: a finished write-back is followed by a fetch request.
    p_wb_then_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == F_WB && done_bus) |=> bus_req &&
            (bus_cmd == BC_READ || bus_cmd == BC_RFO));
endmodule

// File: rtl/wo_snoop_ctrl.sv
// Top: write-once snooping cache controller. Splits addresses into
// index/tag and wires the line store, control FSM and snoop unit.
// Assumes at most one snooped command per cycle.
module wo_snoop_ctrl
    import wo_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              bus_req,
    input  logic              bus_gnt,
    input  logic              bus_done,
    output logic [2:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic [2:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_itv,
    output logic [DATA_W-1:0] snp_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  cpu_idx, snp_idx;
    line_st_t          a_st, b_st, pw_st, sw_st;
    logic [TAG_W-1:0]  a_tag, b_tag, pw_tag;
    logic [DATA_W-1:0] a_data, b_data, pw_data;
    logic              pw_en, sw_en, snp_block;
    bus_cmd_t          cmd;

    assign cpu_idx   = cpu_addr[IDX_W-1:0];
    assign snp_idx   = snp_addr[IDX_W-1:0];
    assign snp_block = snp_valid && (snp_idx == cpu_idx);
    assign cpu_rdata = a_data;
    assign bus_cmd   = cmd;

    wo_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .a_idx(cpu_idx), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
        .b_idx(snp_idx), .b_st(b_st), .b_tag(b_tag), .b_data(b_data),
        .pw_en(pw_en), .pw_idx(cpu_idx), .pw_tag(pw_tag), .pw_data(pw_data), .pw_st(pw_st),
        .sw_en(sw_en), .sw_idx(snp_idx), .sw_st(sw_st)
    );

    wo_ctrl_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_stall(cpu_stall), .snp_block(snp_block),
        .l_st(a_st), .l_tag(a_tag), .l_data(a_data),
        .bus_gnt(bus_gnt), .bus_done(bus_done), .bus_rdata(bus_rdata),
        .bus_req(bus_req), .bus_cmd(cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .pw_en(pw_en), .pw_tag(pw_tag), .pw_data(pw_data), .pw_st(pw_st)
    );

    wo_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_tag(snp_addr[ADDR_W-1:IDX_W]),
        .l_st(b_st), .l_tag(b_tag), .l_data(b_data),
        .itv(snp_itv), .itv_data(snp_data), .upd_en(sw_en), .upd_st(sw_st)
    );

    // R9: intervention only ever answers a snooped command.
    p_itv_on_snoop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        snp_itv |-> snp_valid);
endmodule

// File: tb/wo_snoop_ctrl_test.sv
module wo_snoop_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cpu_req = 0, cpu_we = 0;
    logic [7:0]  cpu_addr = 0;
    logic [15:0] cpu_wdata = 0, cpu_rdata;
    logic        cpu_stall, bus_req, bus_gnt = 0, bus_done = 0;
    logic [2:0]  bus_cmd, snp_cmd = 0;
    logic [7:0]  bus_addr, snp_addr = 0;
    logic [15:0] bus_wdata, bus_rdata = 0, snp_data;
    logic        snp_valid = 0, snp_itv;

    int n_checks = 0, n_fail = 0;
    bit finished = 0;
    logic [15:0] mem [256];
    bit          peer_en = 0;
    logic [15:0] peer_val = 0;

    typedef struct {
        logic [2:0]  cmd;
        logic [7:0]  addr;
        logic [15:0] data;
        bit          chk;
        string       tag;
    } exp_t;
    exp_t sbq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    wo_snoop_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_stall(cpu_stall), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .bus_done(bus_done), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .snp_valid(snp_valid),
        .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_itv(snp_itv), .snp_data(snp_data)
    );

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic expect_bus(logic [2:0] c, logic [7:0] a, logic [15:0] d, bit chk, string tag);
        exp_t e;
        e.cmd = c; e.addr = a; e.data = d; e.chk = chk; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic sb_drained(string tag);
        check(sbq.size() == 0, tag, sbq.size(), 0);
    endtask

    // Memory model and scoreboard monitor: grants, compares, completes.
    initial begin
        logic [2:0] c; logic [7:0] a; logic [15:0] d;
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && bus_req) begin
                c = bus_cmd; a = bus_addr; d = bus_wdata;
                if (sbq.size() == 0) begin
                    check(0, "unexpected bus transaction", {21'd0, c, a}, 0);
                end else begin
                    e = sbq.pop_front();
                    check(c == e.cmd && a == e.addr, e.tag, {21'd0, c, a}, {21'd0, e.cmd, e.addr});
                    if (e.chk) check(d == e.data, e.tag, d, e.data);
                end
                bus_gnt = 1;
                @(negedge clk);
                bus_gnt = 0;
                @(negedge clk);
                case (c)
                    3'd2, 3'd4: mem[a] = d;
                    3'd1: begin
                        if (peer_en) mem[a] = peer_val;
                        bus_rdata = mem[a];
                    end
                    3'd3: bus_rdata = peer_en ? peer_val : mem[a];
                    default: ;
                endcase
                peer_en = 0;
                bus_done = 1;
                @(negedge clk);
                bus_done = 0;
            end
        end
    end

    // Driver: present one processor access, count stalled cycles.
    task automatic cpu_op(bit we, logic [7:0] a, logic [15:0] d,
                          output int n, output logic [15:0] rd);
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        n = 0;
        #1;
        while (cpu_stall && n < 100) begin
            @(negedge clk); #1; n++;
        end
        rd = cpu_rdata;
        @(negedge clk);
        cpu_req = 0; cpu_we = 0;
    endtask

    task automatic snoop(logic [2:0] c, logic [7:0] a, bit exp_itv, logic [15:0] exp_d, string tag);
        @(negedge clk);
        snp_valid = 1; snp_cmd = c; snp_addr = a;
        #1;
        check(snp_itv == exp_itv, tag, snp_itv, exp_itv);
        if (exp_itv) check(snp_data == exp_d, tag, snp_data, exp_d);
        @(negedge clk);
        snp_valid = 0; snp_cmd = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            check(0, "watchdog", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int n; logic [15:0] rd;
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 3 + 1);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        check(cpu_stall == 0 && bus_req == 0 && snp_itv == 0, "R1 idle outputs after reset",
              {cpu_stall, bus_req, snp_itv}, 0);

        // R1/R3: first read misses, fetch fills Valid
        expect_bus(3'd1, 8'h10, 0, 0, "R3 read miss fetch");
        cpu_op(0, 8'h10, 0, n, rd);
        check(rd == 16'h31, "R3 read miss data", rd, 16'h31);
        check(n > 0, "R1 first access stalls", n, 1);
        sb_drained("R3 fetch issued");

        // R2: read hit
        cpu_op(0, 8'h10, 0, n, rd);
        check(n == 0 && rd == 16'h31, "R2 read hit no stall", {n[15:0], rd}, 16'h31);
        sb_drained("R2 no bus on hit");

        // R4: write hit on Valid -> write-through/invalidate, Reserved
        expect_bus(3'd2, 8'h10, 16'hAAAA, 1, "R4 write-through on Valid");
        cpu_op(1, 8'h10, 16'hAAAA, n, rd);
        check(n > 0, "R4 stall until done", n, 1);
        check(mem[8'h10] == 16'hAAAA, "R4 memory updated", mem[8'h10], 16'hAAAA);
        sb_drained("R4 one transaction");

        // R8: snooped read on Reserved -> Valid, no intervention
        snoop(3'd1, 8'h10, 0, 0, "R8 no intervention on Reserved");
        expect_bus(3'd2, 8'h10, 16'hBBBB, 1, "R8 line back to Valid");
        cpu_op(1, 8'h10, 16'hBBBB, n, rd);
        sb_drained("R8 write-through after downgrade");

        // R5: writes to Reserved and Dirty are local
        cpu_op(1, 8'h10, 16'hCCCC, n, rd);
        check(n == 0, "R5 Reserved write local", n, 0);
        cpu_op(1, 8'h10, 16'hDDDD, n, rd);
        check(n == 0, "R5 Dirty write local", n, 0);
        sb_drained("R5 no bus");
        check(mem[8'h10] == 16'hBBBB, "R5 memory not written", mem[8'h10], 16'hBBBB);

        // R9: snooped read on Dirty -> intervention, then Valid
        snoop(3'd1, 8'h10, 1, 16'hDDDD, "R9 intervention on Dirty");
        snoop(3'd1, 8'h10, 0, 0, "R9 line now Valid");

        // R6: write miss -> fetch-for-ownership, Dirty
        expect_bus(3'd3, 8'h21, 0, 0, "R6 write miss ownership fetch");
        cpu_op(1, 8'h21, 16'h1234, n, rd);
        sb_drained("R6 one transaction");
        cpu_op(0, 8'h21, 0, n, rd);
        check(n == 0 && rd == 16'h1234, "R6 written word held", rd, 16'h1234);
        check(mem[8'h21] == 16'h64, "R6 memory untouched", mem[8'h21], 16'h64);

        // R10: snooped ownership fetch on Dirty -> supply, Invalid
        snoop(3'd3, 8'h21, 1, 16'h1234, "R10 Dirty supplies on ownership fetch");
        peer_en = 1; peer_val = 16'h5555;
        expect_bus(3'd1, 8'h21, 0, 0, "R10 line invalid after snoop");
        cpu_op(0, 8'h21, 0, n, rd);
        check(rd == 16'h5555, "R3 fill from other cache's word", rd, 16'h5555);
        sb_drained("R10 refetch");

        // R7: Valid victim dropped silently
        expect_bus(3'd1, 8'h25, 0, 0, "R7 Valid victim no write-back");
        cpu_op(0, 8'h25, 0, n, rd);
        check(rd == 16'h70, "R7 new line data", rd, 16'h70);
        sb_drained("R7 only fetch");

        // R7: Dirty victim written back before the fetch
        expect_bus(3'd2, 8'h25, 16'h7777, 1, "R4 write-through");
        cpu_op(1, 8'h25, 16'h7777, n, rd);
        cpu_op(1, 8'h25, 16'h8888, n, rd);
        expect_bus(3'd4, 8'h25, 16'h8888, 1, "R7 Dirty victim write-back");
        expect_bus(3'd1, 8'h29, 0, 0, "R7 fetch after write-back");
        cpu_op(0, 8'h29, 0, n, rd);
        check(rd == 16'h7C, "R7 data after eviction", rd, 16'h7C);
        check(mem[8'h25] == 16'h8888, "R7 memory has victim", mem[8'h25], 16'h8888);
        sb_drained("R7 both transactions");

        // R7: Reserved victim dropped silently
        expect_bus(3'd2, 8'h29, 16'h9999, 1, "R4 write-through");
        cpu_op(1, 8'h29, 16'h9999, n, rd);
        expect_bus(3'd1, 8'h2D, 0, 0, "R7 Reserved victim no write-back");
        cpu_op(0, 8'h2D, 0, n, rd);
        sb_drained("R7 Reserved dropped");

        // R10: snooped write-through invalidates a Valid line
        snoop(3'd2, 8'h2D, 0, 0, "R10 no intervention on Valid");
        expect_bus(3'd1, 8'h2D, 0, 0, "R10 Valid line invalidated");
        cpu_op(0, 8'h2D, 0, n, rd);
        check(rd == 16'h88, "R10 refetched data", rd, 16'h88);
        sb_drained("R10 refetch after invalidate");

        // R10: snoop with a different tag has no effect
        snoop(3'd3, 8'h30, 0, 0, "R10 tag mismatch no intervention");
        cpu_op(0, 8'h10, 0, n, rd);
        check(n == 0 && rd == 16'hDDDD, "R10 tag mismatch line kept", rd, 16'hDDDD);
        sb_drained("R10 no bus");

        // R11: snoop to same index holds back the hit
        expect_bus(3'd1, 8'h02, 0, 0, "R11 setup fetch");
        cpu_op(0, 8'h02, 0, n, rd);
        @(negedge clk);
        cpu_req = 1; cpu_we = 0; cpu_addr = 8'h02;
        snp_valid = 1; snp_cmd = 3'd1; snp_addr = 8'h06;
        #1;
        check(cpu_stall == 1, "R11 hit stalled by same-index snoop", cpu_stall, 1);
        @(negedge clk);
        snp_valid = 0; snp_cmd = 0;
        #1;
        check(cpu_stall == 0 && cpu_rdata == 16'h7, "R11 hit after snoop", cpu_rdata, 16'h7);
        @(negedge clk);
        cpu_req = 0;
        sb_drained("R11 no extra bus");

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule